// File: doc/BRIEF.md
# Registered 16x16 Multiplier with Selectable Output Format

This block multiplies two 16-bit operands and presents the 32-bit result as two 16-bit halves. Each operand is captured in its own register along with a flag that says whether that operand is two's complement or unsigned. Mixed pairs are allowed, so a signed sample can be scaled by an unsigned gain without any pre-conditioning. A rounding request is captured whenever either operand register loads. When the request is set, the block adds a half-LSB bias so that the upper half alone is a correctly rounded 16-bit result.

A format control picks how the result is presented. One choice splits the raw 32-bit product straight down the middle. The other shifts the product left by one bit to drop the redundant sign bit, and places a copy of the sign in the top bit of the lower half. This second format suits fractional (Q15) arithmetic.

Two output registers hold the halves, and each loads on its own strobe. A bypass control makes both registers transparent. The main 16-bit result port carries either half, chosen by a select input. An auxiliary port always carries the lower half. Each port has its own drive enable, which models a three-state pad. All registers run on a single clock with load strobes and a synchronous active-high reset.

Top module: `pmul16_top`

## Requirements
- R1: A synchronous reset clears the operand registers, their sign flags, the rounding flag and both output registers. On the first cycle after reset, with both enables high, `main_out` and `aux_out` read 0.
- R2: `a_signed`/`b_signed` high marks that operand as two's complement, and low marks it as unsigned. The product P is the low 32 bits of the exact product of the two interpreted operands, in all four sign combinations.
- R3: `ld_a` captures `a_in` and `a_signed`. `ld_b` captures `b_in` and `b_signed`. An operand whose strobe is low keeps its previous value and flag.
- R4: The rounding flag is captured from `rnd_in` on any cycle where `ld_a` or `ld_b` is high, and is held otherwise. When the flag is set, 0x8000 is added to P (modulo 2^32) in full format, and 0x4000 is added in shifted format.
- R5: With `fmt_full` high, the upper half is P[31:16] and the lower half is P[15:0].
- R6: With `fmt_full` low, the upper half is P[30:15] and the lower half is {P[31], P[14:0]}.
- R7: With `bypass` low, the upper-half register loads on `ld_hi` and the lower-half register loads on `ld_lo`. Each holds its value while its strobe is low, even when the operands change.
- R8: With `bypass` high, both halves follow the formatted product in the same cycle, with no output strobe.
- R9: `main_out` carries the upper half when `hi_sel_lo` is 0 and the lower half when it is 1. `aux_out` always carries the lower half.
- R10: `main_drv` equals `oe_main` and `aux_drv` equals `oe_aux`. A port whose enable is low outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a | input | 1 | Load strobe for operand A and its sign flag |
| a_in | input | 16 | Operand A |
| a_signed | input | 1 | 1 = A is two's complement, 0 = unsigned |
| ld_b | input | 1 | Load strobe for operand B and its sign flag |
| b_in | input | 16 | Operand B |
| b_signed | input | 1 | 1 = B is two's complement, 0 = unsigned |
| rnd_in | input | 1 | Rounding request, captured on either operand load |
| fmt_full | input | 1 | 1 = full 32-bit split, 0 = sign-dropped shifted format |
| ld_hi | input | 1 | Load strobe for the upper-half register |
| ld_lo | input | 1 | Load strobe for the lower-half register |
| bypass | input | 1 | 1 = output registers transparent |
| hi_sel_lo | input | 1 | 0 = main port shows upper half, 1 = lower half |
| oe_main | input | 1 | Drive enable for the main port |
| oe_aux | input | 1 | Drive enable for the auxiliary port |
| main_out | output | 16 | Main result port |
| main_drv | output | 1 | Main port drive indication |
| aux_out | output | 16 | Auxiliary lower-half port |
| aux_drv | output | 1 | Auxiliary port drive indication |

## Verification
Rounding and the shifted format act in the same cycle, and the bias position depends on the format. The bench therefore requests rounding with `fmt_full` low on operands whose bit 14 carries into the shifted upper half. It compares the result against a model that adds 0x4000 before the shift. A second collision occurs when an operand load changes the product while the output strobes are idle. There, the bench confirms that the held halves do not move, and then that they track immediately once `bypass` is raised.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int unsigned OPW = 16;
    localparam int unsigned PW  = 2 * OPW;
    localparam int unsigned XW  = OPW + 1;

    typedef logic [OPW-1:0] half_t;
    typedef logic [PW-1:0]  prod_t;

    typedef struct packed {
        half_t val;
        logic  sgn;
    } operand_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } split_t;

    typedef enum logic {
        FMT_SHIFTED = 1'b0,
        FMT_FULL    = 1'b1
    } fmt_e;

    localparam int unsigned HALF_IDX_LO = 0;
    localparam int unsigned HALF_IDX_HI = 1;
    localparam int unsigned NUM_HALVES  = 2;

    // Extend an operand by one bit: sign copy when flagged signed, zero otherwise.
    function automatic logic signed [XW-1:0] widen(operand_t op);
        return $signed({op.sgn & op.val[OPW-1], op.val});
    endfunction

    // Half-LSB bias for the bit that becomes the top of the lower half.
    function automatic prod_t round_bias(logic en, fmt_e f);
        prod_t b;
        b = '0;
        if (en) begin
            if (f == FMT_FULL) b[OPW-1] = 1'b1;
            else               b[OPW-2] = 1'b1;
        end
        return b;
    endfunction

    function automatic split_t arrange(prod_t p, fmt_e f);
        split_t s;
        if (f == FMT_FULL) begin
            s.hi = p[PW-1:OPW];
            s.lo = p[OPW-1:0];
        end else begin
            s.hi = p[PW-2:OPW-1];
            s.lo = {p[PW-1], p[OPW-2:0]};
        end
        return s;
    endfunction

endpackage

// File: rtl/pmul_opnd_reg.sv
module pmul_opnd_reg
    import pmul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld,
    input  half_t    d_val,
    input  logic     d_sgn,
    output operand_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q.val <= d_val;
            q.sgn <= d_sgn;
        end
    end

endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
    import pmul_pkg::*;
(
    input  operand_t a_op,
    input  operand_t b_op,
    input  logic     rnd,
    input  fmt_e     fmt,
    output split_t   halves
);

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;
    prod_t                raw;
    prod_t                biased;

    assign ax     = PW'(widen(a_op));
    assign bx     = PW'(widen(b_op));
    assign raw    = prod_t'(ax * bx);
    assign biased = raw + round_bias(rnd, fmt);
    assign halves = arrange(biased, fmt);

endmodule

// File: rtl/pmul_half_reg.sv
module pmul_half_reg
    import pmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  logic  bypass,
    input  half_t d,
    output half_t held,
    output half_t view
);

    always_ff @(posedge clk) begin
        if (rst)     held <= '0;
        else if (ld) held <= d;
    end

    assign view = bypass ? d : held;

endmodule

// File: rtl/pmul16_top.sv
module pmul16_top
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_a,
    input  logic [OPW-1:0]    a_in,
    input  logic              a_signed,
    input  logic              ld_b,
    input  logic [OPW-1:0]    b_in,
    input  logic              b_signed,
    input  logic              rnd_in,
    input  logic              fmt_full,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              bypass,
    input  logic              hi_sel_lo,
    input  logic              oe_main,
    input  logic              oe_aux,
    output logic [OPW-1:0]    main_out,
    output logic              main_drv,
    output logic [OPW-1:0]    aux_out,
    output logic              aux_drv
);

    operand_t a_q;
    operand_t b_q;
    logic     rnd_q;
    split_t   fmt_res;
    fmt_e     fmt_sel;
    half_t    half_d    [NUM_HALVES];
    half_t    half_held [NUM_HALVES];
    half_t    half_view [NUM_HALVES];
    logic     half_ld   [NUM_HALVES];

    pmul_opnd_reg u_opa (
        .clk(clk), .rst(rst), .ld(ld_a),
        .d_val(a_in), .d_sgn(a_signed), .q(a_q)
    );

    pmul_opnd_reg u_opb (
        .clk(clk), .rst(rst), .ld(ld_b),
        .d_val(b_in), .d_sgn(b_signed), .q(b_q)
    );

    // Rounding flag follows whichever operand register loads.
    always_ff @(posedge clk) begin
        if (rst)              rnd_q <= 1'b0;
        else if (ld_a | ld_b) rnd_q <= rnd_in;
    end

    assign fmt_sel = fmt_full ? FMT_FULL : FMT_SHIFTED;

    pmul_datapath u_dp (
        .a_op(a_q), .b_op(b_q), .rnd(rnd_q), .fmt(fmt_sel), .halves(fmt_res)
    );

    assign half_d[HALF_IDX_HI]  = fmt_res.hi;
    assign half_d[HALF_IDX_LO]  = fmt_res.lo;
    assign half_ld[HALF_IDX_HI] = ld_hi;
    assign half_ld[HALF_IDX_LO] = ld_lo;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        pmul_half_reg u_hreg (
            .clk(clk), .rst(rst), .ld(half_ld[g]), .bypass(bypass),
            .d(half_d[g]), .held(half_held[g]), .view(half_view[g])
        );
    end

    assign main_drv = oe_main;
    assign aux_drv  = oe_aux;
    assign main_out = oe_main ? (hi_sel_lo ? half_view[HALF_IDX_LO]
                                           : half_view[HALF_IDX_HI]) : '0;
    assign aux_out  = oe_aux ? half_view[HALF_IDX_LO] : '0;

endmodule

// File: rtl/pmul16_checks.sv
module pmul16_checks
    import pmul_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     ld_a,
    input logic     ld_b,
    input logic     ld_hi,
    input logic     ld_lo,
    input logic     oe_main,
    input logic     oe_aux,
    input logic     hi_sel_lo,
    input logic     main_drv,
    input logic     aux_drv,
    input half_t    main_out,
    input half_t    aux_out,
    input operand_t a_held,
    input operand_t b_held,
    input logic     rnd_held,
    input half_t    hi_held,
    input half_t    lo_held
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_held == '0 && b_held == '0 && !rnd_held
                        && hi_held == '0 && lo_held == '0));

    a_r3_a_keeps: assert property (@(posedge clk) disable iff (rst)
        !ld_a |=> $stable(a_held));

    a_r3_b_keeps: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(b_held));

    a_r4_rnd_keeps: assert property (@(posedge clk) disable iff (rst)
        !(ld_a || ld_b) |=> $stable(rnd_held));

    a_r7_hi_holds: assert property (@(posedge clk) disable iff (rst)
        !ld_hi |=> $stable(hi_held));

    a_r7_lo_holds: assert property (@(posedge clk) disable iff (rst)
        !ld_lo |=> $stable(lo_held));

    a_r9_lo_on_both: assert property (@(posedge clk) disable iff (rst)
        (oe_main && oe_aux && hi_sel_lo) |-> (main_out == aux_out));

    a_r10_quiet_main: assert property (@(posedge clk) disable iff (rst)
        !main_drv |-> (main_out == '0 && !oe_main));

    a_r10_quiet_aux: assert property (@(posedge clk) disable iff (rst)
        !aux_drv |-> (aux_out == '0 && !oe_aux));

endmodule

bind pmul16_top pmul16_checks u_chk (
    .clk(clk), .rst(rst), .ld_a(ld_a), .ld_b(ld_b),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .oe_main(oe_main), .oe_aux(oe_aux),
    .hi_sel_lo(hi_sel_lo), .main_drv(main_drv), .aux_drv(aux_drv),
    .main_out(main_out), .aux_out(aux_out),
    .a_held(a_q), .b_held(b_q), .rnd_held(rnd_q),
    .hi_held(half_held[HALF_IDX_HI]), .lo_held(half_held[HALF_IDX_LO])
);

// File: tb/tb_pmul16_top.sv
`timescale 1ns/1ps
module tb_pmul16_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_a, a_signed, ld_b, b_signed, rnd_in, fmt_full;
    logic [15:0] a_in, b_in;
    logic        ld_hi, ld_lo, bypass, hi_sel_lo, oe_main, oe_aux;
    logic [15:0] main_out, aux_out;
    logic        main_drv, aux_drv;

    int checks = 0;
    int fails  = 0;

    logic [15:0] cur_a, cur_b;
    logic        cur_as, cur_bs, cur_rnd;

    always #5 clk = ~clk;

    pmul16_top dut (
        .clk(clk), .rst(rst), .ld_a(ld_a), .a_in(a_in), .a_signed(a_signed),
        .ld_b(ld_b), .b_in(b_in), .b_signed(b_signed), .rnd_in(rnd_in),
        .fmt_full(fmt_full), .ld_hi(ld_hi), .ld_lo(ld_lo), .bypass(bypass),
        .hi_sel_lo(hi_sel_lo), .oe_main(oe_main), .oe_aux(oe_aux),
        .main_out(main_out), .main_drv(main_drv),
        .aux_out(aux_out), .aux_drv(aux_drv)
    );

    function automatic logic [31:0] model(logic [15:0] a, logic as, logic [15:0] b,
                                          logic bs, logic rnd, logic full);
        longint va, vb, p;
        logic [31:0] r;
        va = as ? longint'($signed(a)) : longint'(a);
        vb = bs ? longint'($signed(b)) : longint'(b);
        p  = va * vb;
        r  = p[31:0] + (rnd ? (full ? 32'h0000_8000 : 32'h0000_4000) : 32'h0);
        return full ? r : {r[30:15], r[31], r[14:0]};
    endfunction

    function automatic logic [31:0] expect_now();
        return model(cur_a, cur_as, cur_b, cur_bs, cur_rnd, fmt_full);
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Read both halves at the ports (main shows hi, aux shows lo).
    task automatic chk_halves(string req, logic [31:0] exp);
        hi_sel_lo = 1'b0;
        #1;
        chk(req, main_out, exp[31:16]);
        chk(req, aux_out, exp[15:0]);
    endtask

    task automatic load_ops(logic la, logic [15:0] a, logic as,
                            logic lb, logic [15:0] b, logic bs, logic rnd);
        @(negedge clk);
        ld_a = la; a_in = a; a_signed = as;
        ld_b = lb; b_in = b; b_signed = bs; rnd_in = rnd;
        @(negedge clk);
        ld_a = 1'b0; ld_b = 1'b0;
        if (la) begin cur_a = a; cur_as = as; end
        if (lb) begin cur_b = b; cur_bs = bs; end
        if (la || lb) cur_rnd = rnd;
    endtask

    task automatic load_outs(logic h, logic l);
        ld_hi = h; ld_lo = l;
        @(negedge clk);
        ld_hi = 1'b0; ld_lo = 1'b0;
    endtask

    task automatic run_product(string req, logic [15:0] a, logic as,
                               logic [15:0] b, logic bs, logic rnd, logic full);
        fmt_full = full;
        load_ops(1'b1, a, as, 1'b1, b, bs, rnd);
        load_outs(1'b1, 1'b1);
        chk_halves(req, expect_now());
    endtask

    task automatic t_reset();
        // R1: outputs zero right after reset, drives follow enables (R10)
        #1;
        chk("R1", main_out, 16'h0);
        chk("R1", aux_out, 16'h0);
        chk("R10", {15'h0, main_drv}, 16'h1);
    endtask

    task automatic t_sign_modes();
        // R2 and R5: four sign combinations, full format
        run_product("R2", 16'hFFFE, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b1);
        run_product("R2", 16'hFFFE, 1'b1, 16'h0003, 1'b0, 1'b0, 1'b1);
        run_product("R2", 16'h8001, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1);
        run_product("R5", 16'h8000, 1'b1, 16'h7FFF, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_shifted_format();
        // R6: sign-dropped layout, signed, unsigned and the -1.0 * -1.0 corner
        run_product("R6", 16'h4000, 1'b1, 16'hC000, 1'b1, 1'b0, 1'b0);
        run_product("R6", 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        run_product("R6", 16'h8000, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_rounding();
        // R4: bias at bit 15 in full format, bit 14 in shifted format
        run_product("R4", 16'h0101, 1'b0, 16'h0080, 1'b0, 1'b1, 1'b1);
        run_product("R4", 16'h1234, 1'b1, 16'h5678, 1'b1, 1'b1, 1'b0);
        run_product("R4", 16'hFFFF, 1'b1, 16'hC000, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_rnd_capture();
        // R4: flag taken on an A-only load, held while idle, replaced on a B-only load
        bypass = 1'b1; fmt_full = 1'b1;
        load_ops(1'b1, 16'h0003, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
        chk_halves("R4", expect_now());
        @(negedge clk); rnd_in = 1'b0;
        @(negedge clk);
        chk_halves("R4", expect_now());
        load_ops(1'b0, 16'h0, 1'b0, 1'b1, cur_b, cur_bs, 1'b0);
        chk_halves("R4", expect_now());
        bypass = 1'b0;
    endtask

    task automatic t_independent();
        // R3: loading only A keeps B and its flag
        fmt_full = 1'b1;
        run_product("R3", 16'h0010, 1'b1, 16'hFFF0, 1'b1, 1'b0, 1'b1);
        load_ops(1'b1, 16'h0100, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        load_outs(1'b1, 1'b1);
        chk_halves("R3", model(16'h0100, 1'b1, 16'hFFF0, 1'b1, 1'b0, 1'b1));
    endtask

    task automatic t_hold_and_strobes();
        logic [31:0] before_v, after_v;
        // R7: operands change while output strobes idle, then hi only, then lo
        fmt_full = 1'b1;
        run_product("R7", 16'h1111, 1'b0, 16'h0011, 1'b0, 1'b0, 1'b1);
        before_v = expect_now();
        load_ops(1'b1, 16'h2222, 1'b0, 1'b1, 16'h0F0F, 1'b0, 1'b0);
        after_v = expect_now();
        chk_halves("R7", before_v);
        load_outs(1'b1, 1'b0);
        chk_halves("R7", {after_v[31:16], before_v[15:0]});
        load_outs(1'b0, 1'b1);
        chk_halves("R7", after_v);
    endtask

    task automatic t_bypass();
        // R8: transparent halves follow new operands without output strobes
        fmt_full = 1'b0;
        bypass = 1'b1;
        load_ops(1'b1, 16'hA5A5, 1'b1, 1'b1, 16'h3C3C, 1'b0, 1'b0);
        chk_halves("R8", expect_now());
        fmt_full = 1'b1;
        #1;
        chk_halves("R8", expect_now());
        bypass = 1'b0;
    endtask

    task automatic t_mux_and_enables();
        logic [31:0] e;
        // R9: select routes lower half to main; R10: disabled ports read zero
        fmt_full = 1'b1;
        run_product("R9", 16'h1357, 1'b0, 16'h2468, 1'b0, 1'b0, 1'b1);
        e = expect_now();
        hi_sel_lo = 1'b1; #1;
        chk("R9", main_out, e[15:0]);
        oe_main = 1'b0; #1;
        chk("R10", main_out, 16'h0);
        chk("R10", {15'h0, main_drv}, 16'h0);
        oe_aux = 1'b0; #1;
        chk("R10", aux_out, 16'h0);
        chk("R10", {15'h0, aux_drv}, 16'h0);
        oe_main = 1'b1; oe_aux = 1'b1; hi_sel_lo = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ld_a = 0; ld_b = 0; a_in = 0; b_in = 0; a_signed = 0; b_signed = 0;
        rnd_in = 0; fmt_full = 1'b0; ld_hi = 0; ld_lo = 0; bypass = 0;
        hi_sel_lo = 0; oe_main = 1'b1; oe_aux = 1'b1;
        cur_a = 0; cur_b = 0; cur_as = 0; cur_bs = 0; cur_rnd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sign_modes();
        t_shifted_format();
        t_rounding();
        t_rnd_capture();
        t_independent();
        t_hold_and_strobes();
        t_bypass();
        t_mux_and_enables();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule